// File: doc/BRIEF.md
# Dual-Issue Pair Cycle Evaluator

This block looks at two instructions that were issued together, the first in the primary lane and the second in the secondary lane. It decides whether the two overlap fully ("perfect") and how many clock cycles the pair occupies. Each instruction arrives as a descriptor with these fields:

- an operation class,
- a flag that says whether it touches memory,
- an effective byte address,
- an extra-latency count.

The secondary descriptor also carries an address-generation-stall flag. Instruction decode, cache lookups and branch prediction happen elsewhere, so the stall flag and the latency counts arrive already computed.

The cycle cost starts from an asymmetric class-by-class table. Three rules can raise that cost or mark the pair as imperfect:

- two memory accesses in the same 4-byte word,
- two memory accesses whose bank bits match,
- an address-generation stall on the second instruction.

When both instructions carry extra latency, the two latencies partly overlap.

A request is taken with a valid/ready handshake. The result is held in a single output register until the consumer accepts it.

Top module: `pair_eval`

## Requirements
- R1: Class codes are 0 = register-only or plain move (1 cycle alone), 1 = read/modify (2 cycles), 2 = read/modify/write (3 cycles), and 3 is treated as 2. With no memory conflict, no stall and zero latency, the pair cost comes from a table indexed by (first, second): row 0 gives 1,2,3; row 1 gives 2,2,3; row 2 gives 3,4,5.
- R2: The table is asymmetric. Read/modify/write followed by read/modify costs 4 with reason 4. The reverse order costs 3 with reason 0. Reason 4 means the table entry exceeds the larger single-instruction cost.
- R3: If both instructions access memory and address bits 31:2 are equal, the reason is 1 and the base cost becomes max(table, 2).
- R4: If both instructions access memory, bits 31:2 differ and bits 4:2 are equal (bank clash), the reason is 2 and the base cost becomes max(table, 2).
- R5: If either instruction does not access memory, or if the bank bits 4:2 differ, addresses have no effect. For example, byte addresses 0x103 and 0x104 pair perfectly in 1 cycle.
- R6: A stall flag on the secondary lane adds exactly 1 cycle and gives reason 3 when no memory conflict applies.
- R7: Extra latencies combine as follows. If only one is nonzero, it is added. If both are nonzero, max(a,b) + ceil(min(a,b)/2) is added and the reason is 5 when nothing else applies.
- R8: When several causes apply, the reason is the lowest nonzero code. Reason codes are 0 none, 1 same word, 2 bank, 3 stall, 4 class table, 5 dual latency. The extra costs always add up.
- R9: The perfect flag is 1 exactly when the reason is 0.
- R10: The output becomes valid in the cycle after a request is accepted. The output holds steady while it is valid and not accepted. `in_ready` is low exactly when the output is valid and not accepted.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor pair offered |
| in_ready | output | 1 | Descriptor pair can be taken |
| u_cls | input | 2 | Primary-lane operation class |
| u_mem | input | 1 | Primary lane accesses memory |
| u_addr | input | ADDR_W | Primary-lane byte address |
| u_lat | input | LAT_W | Primary-lane extra latency |
| v_cls | input | 2 | Secondary-lane operation class |
| v_mem | input | 1 | Secondary lane accesses memory |
| v_addr | input | ADDR_W | Secondary-lane byte address |
| v_agi | input | 1 | Secondary lane suffers an address-generation stall |
| v_lat | input | LAT_W | Secondary-lane extra latency |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer accepts result |
| out_perfect | output | 1 | Pair overlaps fully |
| out_reason | output | 3 | Reason code for imperfection |
| out_cycles | output | LAT_W+2 | Cycles taken by the pair |

## Verification
The bench targets these corner cases:

- **Swapped table order.** It runs read/modify/write then read/modify, and the same pair in reverse order. A symmetric table would report 4 cycles for both.
- **Neighbouring addresses.** Addresses that straddle a word boundary must not be flagged. Addresses 32000 bytes apart share bank bits and must be flagged. A comparator on the wrong bit range misreports one of these two.
- **Overlapping causes.** Pairs where several causes apply together expose a wrong priority order in the reason code. A latency merge that rounds down, or simply sums, gives the wrong count.
- **Consumer stalls.** Random stalls on the consumer side would let a design that ignores `out_ready` overwrite or drop results. The scoreboard sees that as a mismatch or a missing item.

// File: rtl/pair_pkg.sv
`timescale 1ns/1ps
package pair_pkg;

  typedef enum logic [1:0] {
    CLS_MOVE  = 2'd0,
    CLS_RDMOD = 2'd1,
    CLS_RMW   = 2'd2,
    CLS_RSV   = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_SAME_WORD = 3'd1,
    RSN_BANK      = 3'd2,
    RSN_AGI       = 3'd3,
    RSN_CLASS     = 3'd4,
    RSN_DUAL_LAT  = 3'd5
  } reason_e;

  // Cost of one instruction on its own.
  function automatic logic [2:0] single_cost(input logic [1:0] cls);
    case (cls)
      CLS_MOVE:  single_cost = 3'd1;
      CLS_RDMOD: single_cost = 3'd2;
      default:   single_cost = 3'd3;
    endcase
  endfunction

  // Pair cost before memory, stall and latency adjustments.
  function automatic logic [2:0] pair_table(input logic [1:0] cu, input logic [1:0] cv);
    logic [1:0] a;
    logic [1:0] b;
    a = (cu == CLS_RSV) ? CLS_RMW : cu;
    b = (cv == CLS_RSV) ? CLS_RMW : cv;
    case ({a, b})
      {CLS_MOVE,  CLS_MOVE }: pair_table = 3'd1;
      {CLS_MOVE,  CLS_RDMOD}: pair_table = 3'd2;
      {CLS_MOVE,  CLS_RMW  }: pair_table = 3'd3;
      {CLS_RDMOD, CLS_MOVE }: pair_table = 3'd2;
      {CLS_RDMOD, CLS_RDMOD}: pair_table = 3'd2;
      {CLS_RDMOD, CLS_RMW  }: pair_table = 3'd3;
      {CLS_RMW,   CLS_MOVE }: pair_table = 3'd3;
      {CLS_RMW,   CLS_RDMOD}: pair_table = 3'd4;
      default:                pair_table = 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/pair_mem_check.sv
`timescale 1ns/1ps
module pair_mem_check #(
  parameter int ADDR_W    = 32,
  parameter int WORD_LSB  = 2,
  parameter int BANK_BITS = 3
) (
  input  logic              u_mem,
  input  logic [ADDR_W-1:0] u_addr,
  input  logic              v_mem,
  input  logic [ADDR_W-1:0] v_addr,
  output logic              same_word,
  output logic              bank_clash
);
  localparam int BANK_HI = WORD_LSB + BANK_BITS - 1;

  logic both_mem;
  assign both_mem   = u_mem && v_mem;
  assign same_word  = both_mem && (u_addr[ADDR_W-1:WORD_LSB] == v_addr[ADDR_W-1:WORD_LSB]);
  assign bank_clash = both_mem && (u_addr[BANK_HI:WORD_LSB] == v_addr[BANK_HI:WORD_LSB]);
endmodule

// File: rtl/pair_cost.sv
`timescale 1ns/1ps
module pair_cost
  import pair_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int CYC_W = LAT_W + 2
) (
  input  logic [1:0]       cls_u,
  input  logic [1:0]       cls_v,
  input  logic             same_word,
  input  logic             bank_clash,
  input  logic             agi_v,
  input  logic [LAT_W-1:0] lat_u,
  input  logic [LAT_W-1:0] lat_v,
  output logic [CYC_W-1:0] cycles,
  output logic [2:0]       reason,
  output logic             perfect,
  output logic             class_penalty,
  output logic             dual_lat
);
  localparam int LX_W = LAT_W + 1;

  // Overlapped latency: the larger one in full plus half of the smaller, rounded up.
  function automatic logic [LX_W-1:0] merge_lat(input logic [LAT_W-1:0] a, input logic [LAT_W-1:0] b);
    logic [LX_W-1:0] hi;
    logic [LX_W-1:0] lo;
    hi = (a > b) ? {1'b0, a} : {1'b0, b};
    lo = (a > b) ? {1'b0, b} : {1'b0, a};
    if (a != '0 && b != '0) merge_lat = hi + ((lo + LX_W'(1)) >> 1);
    else                    merge_lat = hi + lo;
  endfunction

  logic [2:0]      tbl;
  logic [2:0]      solo_max;
  logic [2:0]      core;
  logic            mem_conf;
  logic [LX_W-1:0] lat_add;

  always_comb begin
    tbl           = pair_table(cls_u, cls_v);
    solo_max      = (single_cost(cls_u) > single_cost(cls_v)) ? single_cost(cls_u) : single_cost(cls_v);
    class_penalty = tbl > solo_max;
    mem_conf      = same_word || bank_clash;
    core          = (mem_conf && tbl < 3'd2) ? 3'd2 : tbl;
    dual_lat      = (lat_u != '0) && (lat_v != '0);
    lat_add       = merge_lat(lat_u, lat_v);
    cycles        = CYC_W'(core) + CYC_W'(agi_v) + CYC_W'(lat_add);
    perfect       = !(mem_conf || agi_v || class_penalty || dual_lat);
    if (same_word)          reason = RSN_SAME_WORD;
    else if (bank_clash)    reason = RSN_BANK;
    else if (agi_v)         reason = RSN_AGI;
    else if (class_penalty) reason = RSN_CLASS;
    else if (dual_lat)      reason = RSN_DUAL_LAT;
    else                    reason = RSN_NONE;
  end
endmodule

// File: rtl/pair_eval.sv
`timescale 1ns/1ps
module pair_eval #(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 4,
  parameter int CYC_W  = LAT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        u_cls,
  input  logic              u_mem,
  input  logic [ADDR_W-1:0] u_addr,
  input  logic [LAT_W-1:0]  u_lat,
  input  logic [1:0]        v_cls,
  input  logic              v_mem,
  input  logic [ADDR_W-1:0] v_addr,
  input  logic              v_agi,
  input  logic [LAT_W-1:0]  v_lat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_perfect,
  output logic [2:0]        out_reason,
  output logic [CYC_W-1:0]  out_cycles
);
  // Internal events, named for the checker.
  logic             ev_accept;
  logic             ev_same_word;
  logic             ev_bank;
  logic             ev_class_pen;
  logic             ev_dual_lat;
  logic [CYC_W-1:0] nx_cycles;
  logic [2:0]       nx_reason;
  logic             nx_perfect;

  pair_mem_check #(.ADDR_W(ADDR_W)) u_mem_chk (
    .u_mem     (u_mem),
    .u_addr    (u_addr),
    .v_mem     (v_mem),
    .v_addr    (v_addr),
    .same_word (ev_same_word),
    .bank_clash(ev_bank)
  );

  pair_cost #(.LAT_W(LAT_W), .CYC_W(CYC_W)) u_cost (
    .cls_u        (u_cls),
    .cls_v        (v_cls),
    .same_word    (ev_same_word),
    .bank_clash   (ev_bank),
    .agi_v        (v_agi),
    .lat_u        (u_lat),
    .lat_v        (v_lat),
    .cycles       (nx_cycles),
    .reason       (nx_reason),
    .perfect      (nx_perfect),
    .class_penalty(ev_class_pen),
    .dual_lat     (ev_dual_lat)
  );

  assign in_ready  = !out_valid || out_ready;
  assign ev_accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_perfect <= 1'b0;
      out_reason  <= '0;
      out_cycles  <= '0;
    end else if (ev_accept) begin
      out_valid   <= 1'b1;
      out_perfect <= nx_perfect;
      out_reason  <= nx_reason;
      out_cycles  <= nx_cycles;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/pair_eval_chk.sv
`timescale 1ns/1ps
module pair_eval_chk #(
  parameter int CYC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_perfect,
  input logic [2:0]       out_reason,
  input logic [CYC_W-1:0] out_cycles,
  input logic             ev_accept,
  input logic             ev_same_word,
  input logic             ev_bank,
  input logic             ev_class_pen,
  input logic             v_agi
);
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cycles) && $stable(out_reason) && $stable(out_perfect));

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_same_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && ev_same_word |=> out_reason == 3'd1 && out_cycles >= CYC_W'(2));

  assert_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && ev_bank && !ev_same_word |=> out_reason == 3'd2 && out_cycles >= CYC_W'(2));

  assert_agi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && v_agi |=> !out_perfect && out_cycles >= CYC_W'(2));

  assert_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && ev_class_pen |=> out_cycles >= CYC_W'(4) && !out_perfect);

  assert_perfect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_perfect == (out_reason == 3'd0));

  assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_reason <= 3'd5 && out_cycles != '0);
endmodule

bind pair_eval pair_eval_chk #(.CYC_W(CYC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_perfect (out_perfect),
  .out_reason  (out_reason),
  .out_cycles  (out_cycles),
  .ev_accept   (ev_accept),
  .ev_same_word(ev_same_word),
  .ev_bank     (ev_bank),
  .ev_class_pen(ev_class_pen),
  .v_agi       (v_agi)
);

// File: tb/test_pair_eval.sv
`timescale 1ns/1ps
module test_pair_eval;
  localparam int ADDR_W = 32;
  localparam int LAT_W  = 4;
  localparam int CYC_W  = LAT_W + 2;

  typedef struct {
    int    cyc;
    int    rsn;
    bit    perf;
    string tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        u_cls = '0;
  logic              u_mem = 1'b0;
  logic [ADDR_W-1:0] u_addr = '0;
  logic [LAT_W-1:0]  u_lat = '0;
  logic [1:0]        v_cls = '0;
  logic              v_mem = 1'b0;
  logic [ADDR_W-1:0] v_addr = '0;
  logic              v_agi = 1'b0;
  logic [LAT_W-1:0]  v_lat = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic              out_perfect;
  logic [2:0]        out_reason;
  logic [CYC_W-1:0]  out_cycles;

  int   n_checks = 0;
  int   n_fail = 0;
  bit   stall_mode = 1'b0;
  bit   finished = 1'b0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  pair_eval #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) i_pair_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .u_cls(u_cls), .u_mem(u_mem), .u_addr(u_addr), .u_lat(u_lat),
    .v_cls(v_cls), .v_mem(v_mem), .v_addr(v_addr), .v_agi(v_agi), .v_lat(v_lat),
    .out_valid(out_valid), .out_ready(out_ready), .out_perfect(out_perfect),
    .out_reason(out_reason), .out_cycles(out_cycles)
  );

  // Reference model, written from the requirements.
  function automatic exp_t model(int cu, int cv, bit mu, bit mv, int au, int av,
                                 bit agi, int lu, int lv, string tag);
    exp_t e;
    int a, b, su, sv, base, core, lat, hi, lo;
    bit sw, bk, cp, dl;
    a  = (cu == 3) ? 2 : cu;
    b  = (cv == 3) ? 2 : cv;
    su = a + 1;
    sv = b + 1;
    cp = (a == 2) && (b >= 1);
    base = cp ? (su + sv - 1) : ((su > sv) ? su : sv);
    sw = mu && mv && ((au >>> 2) == (av >>> 2));
    bk = mu && mv && (((au >>> 2) & 7) == ((av >>> 2) & 7));
    core = ((sw || bk) && base < 2) ? 2 : base;
    dl = (lu != 0) && (lv != 0);
    hi = (lu > lv) ? lu : lv;
    lo = (lu > lv) ? lv : lu;
    lat = dl ? (hi + (lo + 1) / 2) : (lu + lv);
    e.cyc = core + (agi ? 1 : 0) + lat;
    e.rsn = sw ? 1 : bk ? 2 : agi ? 3 : cp ? 4 : dl ? 5 : 0;
    e.perf = (e.rsn == 0);
    e.tag = tag;
    return e;
  endfunction

  task automatic send(int cu, int cv, bit mu, bit mv, int au, int av,
                      bit agi, int lu, int lv, string tag);
    bit acc;
    @(posedge clk);
    #1;
    u_cls = 2'(cu); v_cls = 2'(cv); u_mem = mu; v_mem = mv;
    u_addr = ADDR_W'(au); v_addr = ADDR_W'(av); v_agi = agi;
    u_lat = LAT_W'(lu); v_lat = LAT_W'(lv);
    in_valid = 1'b1;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
    end while (!acc);
    sb.push_back(model(cu, cv, mu, mv, au, av, agi, lu, lv, tag));
    #1;
    in_valid = 1'b0;
  endtask

  // Consumer side: ready pattern.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Monitor: pop and compare on each transfer.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        n_checks++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R10: unexpected result cyc=%0d rsn=%0d, expected none", out_cycles, out_reason);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (int'(out_cycles) != e.cyc || int'(out_reason) != e.rsn || out_perfect != e.perf) begin
            n_fail++;
            $display("FAIL %s: cyc=%0d rsn=%0d perf=%0d, expected cyc=%0d rsn=%0d perf=%0d",
                     e.tag, out_cycles, out_reason, out_perfect, e.cyc, e.rsn, e.perf);
          end
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R11: out_valid=%0d in_ready=%0d, expected 0 and 1", out_valid, in_ready);
    end

    // R1: full class table, no memory, no stall, no latency.
    for (int cu = 0; cu < 4; cu++)
      for (int cv = 0; cv < 4; cv++)
        send(cu, cv, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: asymmetric order.
    send(2, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    send(1, 2, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R3: same word.
    send(0, 0, 1, 1, 32'h100, 32'h101, 0, 0, 0, "R3");
    send(1, 1, 1, 1, 32'h200, 32'h203, 0, 0, 0, "R3");
    // R5: word boundary, one non-memory access, bank differs.
    send(0, 0, 1, 1, 32'h103, 32'h104, 0, 0, 0, "R5");
    send(0, 0, 1, 0, 32'h100, 32'h100, 0, 0, 0, "R5");
    send(0, 0, 1, 1, 32'h100, 32'h100 + 32004, 0, 0, 0, "R5");
    // R4: bank clash at a 32000-byte distance.
    send(0, 0, 1, 1, 32'h100, 32'h100 + 32000, 0, 0, 0, "R4");
    send(2, 0, 1, 1, 32'h40, 32'h60, 0, 0, 0, "R4");
    // R6: stall on the second lane.
    send(0, 0, 0, 0, 0, 0, 1, 0, 0, "R6");
    send(1, 2, 0, 0, 0, 0, 1, 0, 0, "R6");
    // R7: latency merge.
    send(0, 0, 0, 0, 0, 0, 0, 5, 0, "R7");
    send(0, 0, 0, 0, 0, 0, 0, 0, 7, "R7");
    send(0, 0, 0, 0, 0, 0, 0, 5, 3, "R7");
    send(0, 0, 0, 0, 0, 0, 0, 4, 4, "R7");
    send(0, 0, 0, 0, 0, 0, 0, 15, 15, "R7");
    // R8: overlapping causes.
    send(2, 1, 1, 1, 32'h300, 32'h302, 1, 2, 3, "R8");
    send(2, 2, 0, 0, 0, 0, 1, 1, 1, "R8");
    send(2, 2, 0, 0, 0, 0, 0, 1, 1, "R8");
    send(0, 0, 1, 1, 32'h20, 32'h40, 1, 0, 0, "R8");

    // R9 and R10: random traffic under consumer stalls.
    stall_mode = 1'b1;
    for (int k = 0; k < 200; k++) begin
      int au, av;
      au = 32'h1000 + int'($urandom_range(0, 63));
      av = 32'h1000 + int'($urandom_range(0, 63));
      send(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), au, av,
           bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)) * int'($urandom_range(0, 1)),
           int'($urandom_range(0, 15)) * int'($urandom_range(0, 1)), "R9_R10");
    end
    stall_mode = 1'b0;

    while (sb.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule